// File: doc/BRIEF.md
# Linear Address Fault Checker

This block sits on the slow path of a 64-bit-mode load or store. It takes one linear address with a description of the access: its size, whether it is the strictly aligned 16-byte variant, whether it uses the stack segment, whether it is a push onto a new stack, the current privilege level and whether alignment checking is enabled. From these it decides whether the access may proceed or which single fault it raises. A fault carries an exception vector and an error code that is always zero.

The access class sets the order of the checks. The strictly aligned 16-byte variant tests its low four address bits first and raises a general-protection fault before any canonical test. All other accesses test canonical form first, on both the first and the last byte. Only after that do sizes 2, 4 and 8 test alignment. New-stack pushes always report canonical failures as stack faults, and they check alignment only at privilege level 3.

Results are registered. One cycle after each input strobe a response strobe appears, and the verdict then stays on the outputs until the next strobe. Address translation, segment base addition and the memory access itself belong to neighbouring blocks.

Top module: `laddr_fault_chk`

## Requirements
- R1: `rsp_vld` is high for exactly the one cycle that follows each cycle with `req_vld` high, and is low otherwise. The verdict for a strobe is on the outputs in that same cycle.
- R2: After reset `rsp_vld`, `rsp_fault` and `rsp_vector` are 0. `rsp_fault` and `rsp_vector` keep their values until the next strobe, whatever the inputs do in between.
- R3: `req_size` is a log2 code: 0=1, 1=2, 2=4, 3=8 and 4=16 bytes. An access is canonical only if both `addr` and `addr+size-1` (modulo 2^64) have bits 63 down to 47 all equal.
- R4: A canonical failure raises vector 12 when `req_newstk` or `req_stkseg` is set, and vector 13 otherwise.
- R5: For sizes 2, 4 and 8, with `req_acen`=1 and any of the low size-1 address bits set, vector 17 is raised.
- R6: Sizes 2, 4 and 8 check canonical form before alignment: a non-canonical misaligned access reports the canonical vector, never 17.
- R7: 1-byte accesses and 16-byte accesses with `req_aln16`=0 never raise vector 17.
- R8: A 16-byte access with `req_aln16`=1 raises vector 13 when any of address bits 3..0 is set. This test precedes the canonical test. `req_aln16` has no effect for other sizes.
- R9: With `req_newstk`=1, vector 17 is raised only when `req_cpl`=3.
- R10: With `req_acen`=0, vector 17 is never raised.
- R11: `rsp_errcode` is always 0. When `rsp_fault` is 0, `rsp_vector` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| req_addr | input | 64 | Linear address |
| req_size | input | 3 | Access size as log2 of bytes |
| req_aln16 | input | 1 | Strictly aligned 16-byte variant |
| req_stkseg | input | 1 | Access uses the stack segment |
| req_newstk | input | 1 | Push onto a new stack |
| req_cpl | input | 2 | Current privilege level |
| req_acen | input | 1 | Alignment checking enabled |
| rsp_vld | output | 1 | Response strobe |
| rsp_fault | output | 1 | Access faults |
| rsp_vector | output | 8 | Exception vector (0 when no fault) |
| rsp_errcode | output | 16 | Error code, always 0 |

## Verification
Every result of this block is due in the single cycle after the strobe. Response strobe, fault flag, vector and error code all pass through one register stage. Each scenario task drives the request on a falling edge and drops the strobe on the next falling edge. It samples all outputs there, half a period after the capturing rising edge. It then scrambles the inputs and samples again one cycle later, to show that the strobe has fallen and the verdict has held.

// File: rtl/laf_pkg.sv
package laf_pkg;
   // Access size codes (log2 of bytes)
   localparam logic [2:0] SZ_1  = 3'd0;
   localparam logic [2:0] SZ_2  = 3'd1;
   localparam logic [2:0] SZ_4  = 3'd2;
   localparam logic [2:0] SZ_8  = 3'd3;
   localparam logic [2:0] SZ_16 = 3'd4;

   // Privilege level at which new-stack alignment checking applies
   localparam logic [1:0] CPL_USER = 2'd3;

   typedef struct packed {
      logic       fault;
      logic [7:0] vector;
   } verdict_t;
endpackage

// File: rtl/laf_canon_chk.sv
module laf_canon_chk #(
   parameter int ADDR_W = 64,
   parameter int VA_W   = 48,
   parameter int SZ_W   = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SZ_W-1:0]   size_log2,
   output logic              noncanon
);
   localparam int HI_W   = ADDR_W - VA_W + 1;
   localparam int NPROBE = 2;

   if (VA_W < 2 || VA_W >= ADDR_W) begin : g_bad_va
      $error("laf_canon_chk: VA_W must lie in 2..ADDR_W-1");
   end

   logic [ADDR_W-1:0] span_m1;
   logic [ADDR_W-1:0] probe [NPROBE];
   logic [NPROBE-1:0] ok;

   assign span_m1  = (ADDR_W'(1) << size_log2) - ADDR_W'(1);
   assign probe[0] = addr;
   assign probe[1] = addr + span_m1;

   for (genvar i = 0; i < NPROBE; i++) begin : g_probe
      logic [HI_W-1:0] hi;
      assign hi    = probe[i][ADDR_W-1:VA_W-1];
      assign ok[i] = (hi == {HI_W{1'b0}}) || (hi == {HI_W{1'b1}});
   end

   assign noncanon = ~&ok;
endmodule

// File: rtl/laf_align_chk.sv
module laf_align_chk #(
   parameter int MAX_LOG2 = 4,
   parameter int SZ_W     = 3
) (
   input  logic [MAX_LOG2-1:0] addr_lo,
   input  logic [SZ_W-1:0]     size_log2,
   output logic                misal
);
   if (MAX_LOG2 < 1 || MAX_LOG2 >= (1 << SZ_W)) begin : g_bad_log2
      $error("laf_align_chk: MAX_LOG2 out of range for SZ_W");
   end

   logic [MAX_LOG2-1:0] mask;

   for (genvar b = 0; b < MAX_LOG2; b++) begin : g_mask
      assign mask[b] = (size_log2 > SZ_W'(b));
   end

   assign misal = |(addr_lo & mask);
endmodule

// File: rtl/laf_fault_sel.sv
module laf_fault_sel
   import laf_pkg::*;
#(
   parameter logic [7:0] VEC_SS = 8'd12,
   parameter logic [7:0] VEC_GP = 8'd13,
   parameter logic [7:0] VEC_AC = 8'd17
) (
   input  logic       is_aln16,
   input  logic       aln16_misal,
   input  logic       noncanon,
   input  logic       misal,
   input  logic [2:0] size_log2,
   input  logic       stkseg,
   input  logic       newstk,
   input  logic [1:0] cpl,
   input  logic       acen,
   output verdict_t   verdict
);
   logic ac_size;
   logic ac_allowed;
   logic [7:0] canon_vec;

   assign ac_size    = (size_log2 == SZ_2) || (size_log2 == SZ_4) || (size_log2 == SZ_8);
   assign ac_allowed = acen && ac_size && (!newstk || cpl == CPL_USER);
   assign canon_vec  = (newstk || stkseg) ? VEC_SS : VEC_GP;

   always_comb begin
      verdict = '0;
      if (is_aln16) begin
         if (aln16_misal) begin
            verdict.fault  = 1'b1;
            verdict.vector = VEC_GP;
         end else if (noncanon) begin
            verdict.fault  = 1'b1;
            verdict.vector = canon_vec;
         end
      end else if (noncanon) begin
         verdict.fault  = 1'b1;
         verdict.vector = canon_vec;
      end else if (ac_allowed && misal) begin
         verdict.fault  = 1'b1;
         verdict.vector = VEC_AC;
      end
   end

   // R7
   no_ac_small_chk: assert final (!(verdict.vector == VEC_AC) || ac_size);
   // R10
   no_ac_disabled_chk: assert final (!(verdict.vector == VEC_AC) || acen);
endmodule

// File: rtl/laddr_fault_chk.sv
module laddr_fault_chk
   import laf_pkg::*;
#(
   parameter int         ADDR_W   = 64,
   parameter int         VA_W     = 48,
   parameter int         MAX_LOG2 = 4,
   parameter int         VEC_W    = 8,
   parameter int         ERR_W    = 16,
   parameter logic [7:0] VEC_SS   = 8'd12,
   parameter logic [7:0] VEC_GP   = 8'd13,
   parameter logic [7:0] VEC_AC   = 8'd17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_size,
   input  logic              req_aln16,
   input  logic              req_stkseg,
   input  logic              req_newstk,
   input  logic [1:0]        req_cpl,
   input  logic              req_acen,
   output logic              rsp_vld,
   output logic              rsp_fault,
   output logic [VEC_W-1:0]  rsp_vector,
   output logic [ERR_W-1:0]  rsp_errcode
);
   localparam int SZ_W = 3;

   if (VEC_W != 8) begin : g_bad_vec
      $error("laddr_fault_chk: VEC_W must be 8");
   end
   if (MAX_LOG2 != 4) begin : g_bad_max
      $error("laddr_fault_chk: only 16-byte maximum access supported");
   end

   logic     noncanon;
   logic     misal;
   logic     is_aln16;
   logic     aln16_misal;
   verdict_t verdict;

   assign is_aln16    = req_aln16 && (req_size == SZ_16);
   assign aln16_misal = |req_addr[MAX_LOG2-1:0];

   laf_canon_chk #(.ADDR_W(ADDR_W), .VA_W(VA_W), .SZ_W(SZ_W)) u_canon (
      .addr     (req_addr),
      .size_log2(req_size),
      .noncanon (noncanon)
   );

   laf_align_chk #(.MAX_LOG2(MAX_LOG2), .SZ_W(SZ_W)) u_align (
      .addr_lo  (req_addr[MAX_LOG2-1:0]),
      .size_log2(req_size),
      .misal    (misal)
   );

   laf_fault_sel #(.VEC_SS(VEC_SS), .VEC_GP(VEC_GP), .VEC_AC(VEC_AC)) u_sel (
      .is_aln16   (is_aln16),
      .aln16_misal(aln16_misal),
      .noncanon   (noncanon),
      .misal      (misal),
      .size_log2  (req_size),
      .stkseg     (req_stkseg),
      .newstk     (req_newstk),
      .cpl        (req_cpl),
      .acen       (req_acen),
      .verdict    (verdict)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld    <= 1'b0;
         rsp_fault  <= 1'b0;
         rsp_vector <= '0;
      end else begin
         rsp_vld <= req_vld;
         if (req_vld) begin
            rsp_fault  <= verdict.fault;
            rsp_vector <= verdict.vector;
         end
      end
   end

   assign rsp_errcode = '0;

   // R1
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_vld);
   // R1
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !rsp_vld);
   // R2
   verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> ($stable(rsp_fault) && $stable(rsp_vector)));
   // R11
   idle_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_fault |-> (rsp_vector == '0));
   // R6
   canon_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && noncanon && !is_aln16) |=> (rsp_fault && rsp_vector != VEC_AC));
   // R4
   newstk_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_newstk && noncanon && !is_aln16) |=> (rsp_vector == VEC_SS));
   // R8
   aln16_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && is_aln16 && aln16_misal) |=> (rsp_vector == VEC_GP));
   // R9
   newstk_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_newstk && req_cpl != CPL_USER) |=> (rsp_vector != VEC_AC));
endmodule

// File: tb/laddr_fault_chk_test.sv
`timescale 1ns/100ps
module laddr_fault_chk_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [63:0] req_addr = '0;
   logic [2:0]  req_size = '0;
   logic        req_aln16 = 1'b0;
   logic        req_stkseg = 1'b0;
   logic        req_newstk = 1'b0;
   logic [1:0]  req_cpl = '0;
   logic        req_acen = 1'b0;
   logic        rsp_vld;
   logic        rsp_fault;
   logic [7:0]  rsp_vector;
   logic [15:0] rsp_errcode;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   laddr_fault_chk uut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
      .req_size(req_size), .req_aln16(req_aln16), .req_stkseg(req_stkseg),
      .req_newstk(req_newstk), .req_cpl(req_cpl), .req_acen(req_acen),
      .rsp_vld(rsp_vld), .rsp_fault(rsp_fault), .rsp_vector(rsp_vector),
      .rsp_errcode(rsp_errcode)
   );

   task automatic check(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Issue one request, check the verdict one cycle later, then check the hold.
   task automatic access(string req, logic [63:0] a, logic [2:0] sz, logic al,
                         logic ss, logic ns, logic [1:0] cpl, logic ac,
                         logic exp_f, int exp_v);
      @(negedge clk);
      req_vld = 1'b1; req_addr = a; req_size = sz; req_aln16 = al;
      req_stkseg = ss; req_newstk = ns; req_cpl = cpl; req_acen = ac;
      @(negedge clk);
      req_vld = 1'b0;
      check({req, " rsp_vld"}, rsp_vld, 1);
      check({req, " fault"}, rsp_fault, exp_f);
      check({req, " vector"}, rsp_vector, exp_v);
      check({req, " R11 errcode"}, rsp_errcode, 0);
      // scramble inputs without a strobe
      req_addr = 64'h8000_0000_0000_0003; req_size = 3'd1; req_acen = 1'b1;
      req_stkseg = ~ss; req_aln16 = ~al;
      @(negedge clk);
      check({req, " R1 strobe low"}, rsp_vld, 0);
      check({req, " R2 fault held"}, rsp_fault, exp_f);
      check({req, " R2 vector held"}, rsp_vector, exp_v);
   endtask

   task automatic t_reset;
      check("R2 reset vld", rsp_vld, 0);
      check("R2 reset fault", rsp_fault, 0);
      check("R2 reset vector", rsp_vector, 0);
   endtask

   task automatic t_canonical;
      access("R3 low half ok",   64'h0000_7FFF_FFFF_FFF8, 3'd3, 0, 0, 0, 0, 1, 0, 0);
      access("R3 high half ok",  64'hFFFF_8000_0000_0000, 3'd2, 0, 0, 0, 0, 1, 0, 0);
      access("R3 last byte bad", 64'h0000_7FFF_FFFF_FFF8, 3'd4, 0, 0, 0, 0, 0, 1, 13);
      access("R3 first byte bad",64'hFFFF_7FFF_FFFF_FFFF, 3'd0, 0, 0, 0, 0, 0, 1, 13);
      access("R3 wrap to zero",  64'hFFFF_FFFF_FFFF_FFFF, 3'd1, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_canon_vector;
      access("R4 stack seg",  64'h1234_0000_0000_0000, 3'd3, 0, 1, 0, 0, 0, 1, 12);
      access("R4 new stack",  64'h1234_0000_0000_0000, 3'd3, 0, 0, 1, 0, 0, 1, 12);
      access("R4 data seg",   64'h1234_0000_0000_0000, 3'd3, 0, 0, 0, 0, 0, 1, 13);
   endtask

   task automatic t_align;
      access("R5 word odd",   64'h0000_0000_0000_1001, 3'd1, 0, 0, 0, 3, 1, 1, 17);
      access("R5 dword +2",   64'h0000_0000_0000_1002, 3'd2, 0, 0, 0, 3, 1, 1, 17);
      access("R5 qword +4",   64'h0000_0000_0000_1004, 3'd3, 0, 0, 0, 3, 1, 1, 17);
      access("R5 qword ok",   64'h0000_0000_0000_1008, 3'd3, 0, 0, 0, 3, 1, 0, 0);
      access("R6 canon wins", 64'h0000_8000_0000_0001, 3'd1, 0, 0, 0, 3, 1, 1, 13);
      access("R7 byte",       64'h0000_0000_0000_1003, 3'd0, 0, 0, 0, 3, 1, 0, 0);
      access("R7 16 unalgn",  64'h0000_0000_0000_1003, 3'd4, 0, 0, 0, 3, 1, 0, 0);
      access("R10 ac off",    64'h0000_0000_0000_1003, 3'd2, 0, 0, 0, 3, 0, 0, 0);
   endtask

   task automatic t_aln16;
      access("R8 gp misal",   64'h0000_0000_0000_1008, 3'd4, 1, 0, 0, 0, 0, 1, 13);
      access("R8 gp before canon", 64'h0000_8000_0000_0001, 3'd4, 1, 1, 0, 0, 0, 1, 13);
      access("R8 aligned canon", 64'h0000_8000_0000_0000, 3'd4, 1, 1, 0, 0, 0, 1, 12);
      access("R8 aligned ok", 64'h0000_0000_0000_1010, 3'd4, 1, 0, 0, 0, 0, 0, 0);
      access("R8 flag ignored", 64'h0000_0000_0000_1004, 3'd3, 1, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_newstk;
      access("R9 kernel no ac", 64'h0000_0000_0000_2002, 3'd2, 0, 0, 1, 0, 1, 0, 0);
      access("R9 user ac",      64'h0000_0000_0000_2002, 3'd2, 0, 0, 1, 3, 1, 1, 17);
   endtask

   task automatic t_back_to_back;
      // R1: two consecutive strobes, each verdict one cycle after its strobe
      @(negedge clk);
      req_vld = 1'b1; req_addr = 64'h0000_0000_0000_0001; req_size = 3'd1;
      req_aln16 = 0; req_stkseg = 0; req_newstk = 0; req_cpl = 3; req_acen = 1;
      @(negedge clk);
      check("R1 b2b first vld", rsp_vld, 1);
      check("R1 b2b first vec", rsp_vector, 17);
      req_addr = 64'h0000_0000_0000_0002;
      @(negedge clk);
      req_vld = 1'b0;
      check("R1 b2b second vld", rsp_vld, 1);
      check("R1 b2b second vec", rsp_vector, 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_canonical();
      t_canon_vector();
      t_align();
      t_aln16();
      t_newstk();
      t_back_to_back();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule